// File: doc/BRIEF.md
# Transmit Loopback Carrier Monitor

While the external attachment-unit port is in use, a transmitting station expects the medium attachment to echo its own outgoing frame back as receive carrier. This block watches that echo. It counts bit times from the start of every transmission and demands that receive carrier appear within a programmable number of bit times. Once the carrier has appeared, it must stay up until the transmission ends. If the carrier arrives late, never arrives, or drops out early, the block raises a sticky loss-of-carrier error flag.

The block takes a transmit-active level, a one-cycle bit-time tick, the receive carrier level, a level that says the attachment-unit port is selected, and a clear strobe. Its only output is the error flag. The flag stays set until the clear strobe or reset. At most one error is reported for each transmission. Line coding and frame contents play no part in the check.

Top module: `txloop_carrier_monitor`

## Requirements
- R1: Synchronous active-high reset returns the error flag to 0 and the tracker to its idle state.
- R2: If carrier is seen within the window and held high until transmit-active falls, the flag stays 0.
- R3: Bit ticks are counted from the cycle after transmit-active is first sampled high. If carrier is still absent in the cycle that carries tick number WINDOW_BITS (default 8), the flag rises on the following clock edge. Carrier sampled high in that same cycle counts as on time.
- R4: Carrier that was seen but is sampled low while transmit-active is still high sets the flag.
- R5: A transmission that ends (transmit-active sampled low) with no carrier seen at any point during it sets the flag, even before the window expires.
- R6: Carrier falling in the same cycle that transmit-active falls is not an error.
- R7: The flag holds at 1 until err_clear is sampled high. A failure in the same cycle as err_clear leaves the flag at 1.
- R8: A failure that occurs while port_sel is low does not set the flag.
- R9: After one failure, nothing else in the same transmission sets the flag again, even if the flag was cleared in between.
- R10: Each new transmission restarts the bit count and forgets any carrier seen in the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_sel | input | 1 | High while the attachment-unit port is the active medium port |
| tx_active | input | 1 | High for the duration of a transmission |
| bit_tick | input | 1 | One-cycle pulse per transmitted bit time |
| rx_carrier | input | 1 | Received carrier level from the loopback path |
| err_clear | input | 1 | Clears the sticky error flag |
| loss_err | output | 1 | Sticky loss-of-carrier error flag |

## Verification
The bench drives several carrier patterns. The first is a prompt echo held to the end, with carrier falling together with transmit-active. The second is an echo that never comes, checked one tick before and at the window limit. The third is an echo landing exactly on the last allowed tick. The fourth is an echo that drops mid-frame. Each pair of patterns differs in one detail, so each case separates on-time carrier from late carrier, and a same-cycle release from a real dropout. Further sequences cover the port deselected, a clear during a failed transmission with a second dropout, back-to-back transmissions that must each get a fresh window, and a clear that collides with a new failure.

// File: rtl/txlc_pkg.sv
package txlc_pkg;

    typedef enum logic [1:0] {
        MON_IDLE = 2'd0,
        MON_WAIT = 2'd1,
        MON_HELD = 2'd2,
        MON_DONE = 2'd3
    } mon_state_e;

    typedef struct packed {
        logic tx;
        logic tick;
        logic crs;
    } line_s;

    typedef struct packed {
        logic clr;
        logic inc;
    } cnt_ctl_s;

    function automatic int ctr_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/txlc_window_cnt.sv
module txlc_window_cnt
    import txlc_pkg::*;
#(
    parameter int WINDOW_BITS = 8
) (
    input  logic     clk,
    input  logic     rst,
    input  cnt_ctl_s ctl,
    output logic     at_last
);
    localparam int CNT_W = ctr_width(WINDOW_BITS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WINDOW_BITS - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || ctl.clr) begin
            cnt_q <= '0;
        end else if (ctl.inc && cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    generate
        if (WINDOW_BITS <= 1) begin : g_single
            assign at_last = 1'b1;
        end else begin : g_multi
            assign at_last = (cnt_q == LAST);
        end
    endgenerate

endmodule

// File: rtl/txlc_tracker.sv
module txlc_tracker
    import txlc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  line_s    line,
    input  logic     at_last,
    output cnt_ctl_s ctl,
    output logic     fail_evt
);
    mon_state_e st_q, st_d;

    always_comb begin
        st_d     = st_q;
        ctl      = '0;
        fail_evt = 1'b0;
        case (st_q)
            MON_IDLE: begin
                ctl.clr = 1'b1;
                if (line.tx) begin
                    st_d = line.crs ? MON_HELD : MON_WAIT;
                end
            end
            MON_WAIT: begin
                if (!line.tx) begin
                    fail_evt = 1'b1;
                    st_d     = MON_IDLE;
                end else if (line.crs) begin
                    st_d = MON_HELD;
                end else if (line.tick) begin
                    if (at_last) begin
                        fail_evt = 1'b1;
                        st_d     = MON_DONE;
                    end else begin
                        ctl.inc = 1'b1;
                    end
                end
            end
            MON_HELD: begin
                if (!line.tx) begin
                    st_d = MON_IDLE;
                end else if (!line.crs) begin
                    fail_evt = 1'b1;
                    st_d     = MON_DONE;
                end
            end
            MON_DONE: begin
                if (!line.tx) begin
                    st_d = MON_IDLE;
                end
            end
            default: st_d = MON_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= MON_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/txlc_err_flag.sv
module txlc_err_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag_o <= 1'b0;
        end else if (set_i) begin
            flag_o <= 1'b1;
        end else if (clr_i) begin
            flag_o <= 1'b0;
        end
    end
endmodule

// File: rtl/txloop_carrier_monitor.sv
module txloop_carrier_monitor
    import txlc_pkg::*;
#(
    parameter int WINDOW_BITS = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic port_sel,
    input  logic tx_active,
    input  logic bit_tick,
    input  logic rx_carrier,
    input  logic err_clear,
    output logic loss_err
);
    line_s    line;
    cnt_ctl_s ctl;
    logic     at_last;
    logic     fail_evt;

    assign line = '{tx: tx_active, tick: bit_tick, crs: rx_carrier};

    txlc_window_cnt #(.WINDOW_BITS(WINDOW_BITS)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .ctl     (ctl),
        .at_last (at_last)
    );

    txlc_tracker u_trk (
        .clk      (clk),
        .rst      (rst),
        .line     (line),
        .at_last  (at_last),
        .ctl      (ctl),
        .fail_evt (fail_evt)
    );

    txlc_err_flag u_flag (
        .clk    (clk),
        .rst    (rst),
        .set_i  (fail_evt & port_sel),
        .clr_i  (err_clear),
        .flag_o (loss_err)
    );

endmodule

// File: rtl/txloop_carrier_monitor_chk.sv
module txloop_carrier_monitor_chk (
    input logic clk,
    input logic rst,
    input logic port_sel,
    input logic tx_active,
    input logic rx_carrier,
    input logic err_clear,
    input logic loss_err
);
    AST_SET_NEEDS_PORT: assert property (@(posedge clk) disable iff (rst)
        $rose(loss_err) |-> $past(port_sel)); // R8

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (loss_err && !err_clear) |=> loss_err); // R7

    AST_FALL_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $fell(loss_err) |-> $past(err_clear)); // R7

    AST_SET_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(loss_err) |-> (!$past(rx_carrier) || !$past(tx_active))); // R4

    AST_SET_TIED_TO_TX: assert property (@(posedge clk) disable iff (rst)
        $rose(loss_err) |-> ($past(tx_active) || $past(tx_active, 2))); // R5
endmodule

bind txloop_carrier_monitor txloop_carrier_monitor_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .port_sel   (port_sel),
    .tx_active  (tx_active),
    .rx_carrier (rx_carrier),
    .err_clear  (err_clear),
    .loss_err   (loss_err)
);

// File: tb/txloop_carrier_monitor_tb_top.sv
module txloop_carrier_monitor_tb_top;
    localparam int WIN = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic port_sel = 1'b1;
    logic tx_active = 1'b0;
    logic bit_tick = 1'b0;
    logic rx_carrier = 1'b0;
    logic err_clear = 1'b0;
    logic loss_err;

    typedef struct {
        logic  val;
        string req;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    bit   finished = 1'b0;

    always #5 clk = ~clk;

    txloop_carrier_monitor #(.WINDOW_BITS(WIN)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .port_sel   (port_sel),
        .tx_active  (tx_active),
        .bit_tick   (bit_tick),
        .rx_carrier (rx_carrier),
        .err_clear  (err_clear),
        .loss_err   (loss_err)
    );

    // monitor: compares the flag against queued expectations at the falling edge
    always @(negedge clk) begin
        while (exp_q.size() > 0) begin
            exp_t it;
            it = exp_q.pop_front();
            checks++;
            if (loss_err !== it.val) begin
                errors++;
                $display("FAIL %s: loss_err=%0b expected %0b", it.req, loss_err, it.val);
            end
        end
    end

    task automatic cyc(input logic t, input logic k, input logic c);
        tx_active  = t;
        bit_tick   = k;
        rx_carrier = c;
        @(posedge clk);
        #2;
    endtask

    task automatic expect_flag(input logic v, input string r);
        exp_t it;
        it.val = v;
        it.req = r;
        exp_q.push_back(it);
    endtask

    task automatic do_clear();
        err_clear = 1'b1;
        cyc(0, 0, 0);
        err_clear = 1'b0;
    endtask

    task automatic ticks_no_crs(input int n);
        for (int i = 0; i < n; i++) begin
            cyc(1, 1, 0);
            cyc(1, 0, 0);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        rst = 1'b0;
        cyc(0, 0, 0);
        expect_flag(0, "R1 reset");

        // R2/R6: prompt echo, carrier falls with tx_active
        cyc(1, 0, 0);
        ticks_no_crs(3);
        cyc(1, 1, 1);
        cyc(1, 0, 1);
        cyc(1, 1, 1);
        cyc(0, 0, 0);
        expect_flag(0, "R2/R6 good frame");
        cyc(0, 0, 0);

        // R3: no carrier, boundary one tick before window
        cyc(1, 0, 0);
        ticks_no_crs(WIN - 1);
        expect_flag(0, "R3 before window end");
        cyc(1, 1, 0);
        expect_flag(1, "R3 window expired");
        cyc(1, 0, 1);
        cyc(0, 0, 0);
        cyc(0, 0, 0);
        expect_flag(1, "R7 sticky");
        do_clear();
        expect_flag(0, "R7 cleared");

        // R3: carrier on the last allowed tick
        cyc(1, 0, 0);
        ticks_no_crs(WIN - 1);
        cyc(1, 1, 1);
        cyc(1, 0, 1);
        cyc(0, 0, 0);
        expect_flag(0, "R3 carrier on last tick");

        // R4: dropout mid frame
        cyc(1, 0, 1);
        cyc(1, 1, 1);
        expect_flag(0, "R4 before dropout");
        cyc(1, 0, 0);
        expect_flag(1, "R4 dropout");
        cyc(0, 0, 0);
        do_clear();

        // R5: tx ends with no carrier before window end
        cyc(1, 0, 0);
        ticks_no_crs(2);
        cyc(0, 0, 0);
        expect_flag(1, "R5 no carrier at all");
        do_clear();
        expect_flag(0, "R7 cleared again");

        // R8: port deselected, late carrier and dropout
        port_sel = 1'b0;
        cyc(1, 0, 0);
        ticks_no_crs(WIN);
        cyc(0, 0, 0);
        cyc(1, 0, 1);
        cyc(1, 0, 0);
        cyc(0, 0, 0);
        expect_flag(0, "R8 port not selected");
        port_sel = 1'b1;
        cyc(0, 0, 0);

        // R9: one error per transmission
        cyc(1, 0, 1);
        cyc(1, 0, 0);
        expect_flag(1, "R9 first dropout");
        err_clear = 1'b1;
        cyc(1, 0, 0);
        err_clear = 1'b0;
        cyc(1, 0, 1);
        cyc(1, 0, 0);
        cyc(1, 1, 0);
        expect_flag(0, "R9 no second error");
        cyc(0, 0, 0);

        // R10: fresh window per transmission
        cyc(1, 0, 0);
        ticks_no_crs(WIN - 2);
        cyc(1, 0, 1);
        cyc(0, 0, 0);
        cyc(1, 0, 0);
        ticks_no_crs(WIN - 2);
        cyc(1, 1, 1);
        cyc(0, 0, 0);
        expect_flag(0, "R10 window restarted");

        // R7: failure and clear in the same cycle
        cyc(1, 0, 1);
        err_clear = 1'b1;
        cyc(1, 0, 0);
        err_clear = 1'b0;
        expect_flag(1, "R7 set beats clear");
        cyc(0, 0, 0);

        @(negedge clk);
        @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not end, actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule